// File: doc/BRIEF.md
# Four-Lane Coefficient Compressor and Decompressor

This block converts lattice polynomial coefficients between their full residue form modulo 3329 and a shortened d-bit form, for four coefficients in every clock cycle. In compress mode each lane scales a 12-bit residue by 2^d, adds half the modulus so that the result rounds to the nearest step, and divides by the modulus. It does the division with a precomputed reciprocal multiply, a shift and one conditional correction. In decompress mode each lane multiplies a d-bit code by the modulus, adds half of 2^d for rounding and shifts right by d.

The width d is chosen per cycle from four values (1, 5, 11, 12), together with the direction. Both travel down the pipeline with the data they belong to, so a stream may change mode or width on any cycle without a bubble. The lanes share nothing but the control inputs. A valid flag follows the data and marks each result two cycles after it was presented.

Top module: `ccd_unit`

## Requirements
- R1: While reset is held low at a rising edge, the following cycle shows out_valid at 0 and every bit of out_coef at 0.
- R2: out_valid equals the in_valid value presented two rising edges earlier, and the lane results carried with it belong to that same input cycle.
- R3: With in_op = 0 (compress) and in_dsel 0, 1 or 2 (d = 1, 5 or 11), each lane outputs floor((x*2^d + 1664) / 3329) mod 2^d for its input x, where x is below 3329.
- R4: Compressing with d = 1 wraps the rounded value 2 to 0, so every input from 2497 up to 3328 gives 0.
- R5: With in_op = 1 (decompress) and d = 1, 5 or 11, each lane outputs floor((y*3329 + 2^(d-1)) / 2^d), where y is the low d bits of the lane input; input bits at positions d and above have no effect.
- R6: With in_dsel = 3 (d = 12), both directions return the 12-bit lane input unchanged.
- R7: A compressed result for d = 1, 5 or 11 has every bit at position d and above at 0.
- R8: Lane i occupies bits [12*i+11 : 12*i] of both in_coef and out_coef, and its result depends only on its own input field.
- R9: Direction and width are taken from the same cycle as the data, so inputs whose in_op and in_dsel change on every cycle each produce their own correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks the current input cycle as carrying data |
| in_op | input | 1 | 0 = compress, 1 = decompress |
| in_dsel | input | 2 | Width code: 0 = 1 bit, 1 = 5 bits, 2 = 11 bits, 3 = 12 bits |
| in_coef | input | 48 | Four 12-bit lane inputs, lane 0 in the low bits |
| out_valid | output | 1 | Marks the current output cycle as carrying results |
| out_coef | output | 48 | Four 12-bit lane results, lane 0 in the low bits |

## Verification
Every lane result and the valid flag are due exactly two rising edges after the input cycle that produced them, since one register stage holds the products and a second holds the corrected result. The bench drives each input on a falling edge and keeps a two-deep list of the values it expects. At each later falling edge it compares the outputs with the oldest entry before it drives the next input, so each comparison falls on the cycle in which the result is due. Compression is checked for every residue at each reduced width, and decompression for every code with random upper bits. Cycles with bubbles and cycles that change direction and width on every input cover the timing of the flag and of the control.

// File: rtl/ccd_pkg.sv
// Shared constants and helpers for the coefficient compress/decompress unit.
// Assumes the modulus 3329 and 12-bit residues throughout.
package ccd_pkg;

    localparam int unsigned CW      = 12;    // residue width
    localparam int unsigned MODQ    = 3329;  // coefficient modulus
    localparam int unsigned LAT     = 2;     // register stages per lane

    typedef enum logic [1:0] {
        DSEL_1  = 2'd0,
        DSEL_5  = 2'd1,
        DSEL_11 = 2'd2,
        DSEL_12 = 2'd3
    } dsel_e;

    typedef enum logic {
        OP_COMP   = 1'b0,
        OP_DECOMP = 1'b1
    } op_e;

    // Translate the width code into the number of compressed bits.
    function automatic logic [3:0] dsel_width(input logic [1:0] code);
        case (code)
            DSEL_1:  return 4'd1;
            DSEL_5:  return 4'd5;
            DSEL_11: return 4'd11;
            default: return 4'd12;
        endcase
    endfunction

    // Mask covering the low d bits of a residue.
    function automatic logic [CW-1:0] low_mask(input logic [3:0] d);
        return CW'((13'd1 << d) - 13'd1);
    endfunction

endpackage

// File: rtl/ccd_valid_pipe.sv
// Shift register that delays the valid flag by STAGES cycles so it lines
// up with the lane results. Assumes STAGES is at least 2.
module ccd_valid_pipe #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_in,
    output logic vld_out
);

    logic [STAGES-1:0] vld_sh;

    // Advance the flag one stage per cycle; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_sh <= '0;
        else        vld_sh <= {vld_sh[STAGES-2:0], vld_in};
    end

    assign vld_out = vld_sh[STAGES-1];

endmodule

// File: rtl/ccd_lane.sv
// One compress/decompress lane, two register stages.
// Stage 1 forms the scaled numerator (or the rounded product) and the
// reciprocal-multiply quotient estimate; stage 2 corrects the estimate,
// shifts, masks to d bits and registers the result.
// Assumes compress inputs are below MODQ; d = 12 passes the input through.
module ccd_lane
    import ccd_pkg::*;
#(
    parameter int unsigned RK = 24            // reciprocal scaling exponent
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_in,
    input  logic [1:0]    dsel_in,
    input  logic [CW-1:0] coef_in,
    output logic [CW-1:0] coef_out
);

    localparam int unsigned MU    = (1 << RK) / MODQ;  // floor(2^RK / q)
    localparam int unsigned EST_W = CW + 1;            // quotient up to 2^11 + 1
    localparam int unsigned MUL_W = RK + 14;           // numerator times MU
    localparam int unsigned REM_W = RK + 2;            // remainder arithmetic

    logic [3:0]       d_in;
    logic [CW-1:0]    m_in;
    logic [RK-1:0]    cmp_num;
    logic [EST_W-1:0] cmp_est;
    logic [RK-1:0]    dec_num;

    logic             s1_op;
    logic [1:0]       s1_dsel;
    logic [RK-1:0]    s1_num;
    logic [EST_W-1:0] s1_est;
    logic [CW-1:0]    s1_raw;

    logic [3:0]       d_s1;
    logic [CW-1:0]    m_s1;
    logic [REM_W-1:0] rem;
    logic [EST_W-1:0] q_fix;
    logic [CW-1:0]    res;

    // Stage 1 arithmetic: rounded numerator, quotient estimate, rounded product.
    always_comb begin
        d_in    = dsel_width(dsel_in);
        m_in    = low_mask(d_in);
        cmp_num = (RK'(coef_in) << d_in) + RK'(MODQ / 2);
        cmp_est = EST_W'((MUL_W'(cmp_num) * MUL_W'(MU)) >> RK);
        dec_num = RK'(coef_in & m_in) * RK'(MODQ) + (RK'(1) << (d_in - 4'd1));
    end

    // Stage 1 registers: keep the operand that the chosen direction needs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_op   <= 1'b0;
            s1_dsel <= 2'd0;
            s1_num  <= '0;
            s1_est  <= '0;
            s1_raw  <= '0;
        end else begin
            s1_op   <= op_in;
            s1_dsel <= dsel_in;
            s1_num  <= (op_e'(op_in) == OP_DECOMP) ? dec_num : cmp_num;
            s1_est  <= cmp_est;
            s1_raw  <= coef_in;
        end
    end

    // Stage 2 arithmetic: one correction step, shift, width mask, passthrough.
    always_comb begin
        d_s1  = dsel_width(s1_dsel);
        m_s1  = low_mask(d_s1);
        rem   = REM_W'(s1_num) - REM_W'(s1_est) * REM_W'(MODQ);
        q_fix = s1_est + EST_W'(rem >= REM_W'(MODQ));
        if (dsel_e'(s1_dsel) == DSEL_12)
            res = s1_raw;
        else if (op_e'(s1_op) == OP_DECOMP)
            res = CW'(s1_num >> d_s1);
        else
            res = CW'(q_fix) & m_s1;
    end

    // Stage 2 register: the lane result.
    always_ff @(posedge clk) begin
        if (!rst_n) coef_out <= '0;
        else        coef_out <= res;
    end

endmodule

// File: rtl/ccd_unit.sv
// Top of the coefficient compress/decompress unit: LANES independent lanes
// sharing the direction and width inputs, plus the delayed valid flag.
// Assumes every lane field is 12 bits, lane 0 in the low bits.
module ccd_unit
    import ccd_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_op,
    input  logic [1:0]          in_dsel,
    input  logic [LANES*CW-1:0] in_coef,
    output logic                out_valid,
    output logic [LANES*CW-1:0] out_coef
);

    // One lane per coefficient field.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        ccd_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .op_in    (in_op),
            .dsel_in  (in_dsel),
            .coef_in  (in_coef[i*CW +: CW]),
            .coef_out (out_coef[i*CW +: CW])
        );
    end

    ccd_valid_pipe #(.STAGES(LAT)) u_vld (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_in  (in_valid),
        .vld_out (out_valid)
    );

endmodule

// File: rtl/ccd_unit_chk.sv
// Property checker for ccd_unit, attached by bind. Looks at the ports only;
// a small age counter keeps two-cycle lookbacks out of the reset period.
module ccd_unit_chk
    import ccd_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_op,
    input logic [1:0]          in_dsel,
    input logic [LANES*CW-1:0] in_coef,
    input logic                out_valid,
    input logic [LANES*CW-1:0] out_coef
);

    logic [1:0] age;

    // Count edges since reset release, saturating at the pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    // R1: reset leaves the outputs cleared.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_coef == '0));

    // R2: valid emerges exactly two edges after it entered.
    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R6: the 12-bit width returns its input.
    a_r6_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && out_valid && $past(in_dsel, 2) == 2'd3)
        |-> (out_coef == $past(in_coef, 2)));

    for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
        // R7: compressed codes carry nothing above bit d-1.
        a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (age == 2'd2 && out_valid && !$past(in_op, 2) && $past(in_dsel, 2) != 2'd3)
            |-> ((out_coef[i*CW +: CW] & ~low_mask(dsel_width($past(in_dsel, 2)))) == '0));

        // R5: one-bit decompression yields only the two rounded levels.
        a_r5_single_bit_levels: assert property (@(posedge clk) disable iff (!rst_n)
            (age == 2'd2 && out_valid && $past(in_op, 2) && $past(in_dsel, 2) == 2'd0)
            |-> (out_coef[i*CW +: CW] == 12'd0 || out_coef[i*CW +: CW] == 12'd1665));
    end

endmodule

bind ccd_unit ccd_unit_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_dsel   (in_dsel),
    .in_coef   (in_coef),
    .out_valid (out_valid),
    .out_coef  (out_coef)
);

// File: tb/ccd_unit_test.sv
// Self-checking bench for ccd_unit: exhaustive residue and code sweeps,
// expected values from plain integer arithmetic, two-deep expectation list.
module ccd_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_op;
    logic [1:0]  in_dsel;
    logic [47:0] in_coef;
    logic        out_valid;
    logic [47:0] out_coef;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    logic        p_v   [2];
    logic        p_op  [2];
    logic [1:0]  p_ds  [2];
    logic [11:0] p_exp [2][4];
    string       p_tag [2][4];

    always #5 clk = ~clk;

    ccd_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_op     (in_op),
        .in_dsel   (in_dsel),
        .in_coef   (in_coef),
        .out_valid (out_valid),
        .out_coef  (out_coef)
    );

    function automatic int dval(input logic [1:0] s);
        case (s)
            2'd0:    return 1;
            2'd1:    return 5;
            2'd2:    return 11;
            default: return 12;
        endcase
    endfunction

    function automatic logic [11:0] ref_comp(input int x, input int d);
        if (d == 12) return 12'(x);
        return 12'((((x << d) + 1664) / 3329) % (1 << d));
    endfunction

    function automatic logic [11:0] ref_dec(input int y, input int d);
        int yy;
        if (d == 12) return 12'(y);
        yy = y % (1 << d);
        return 12'((yy * 3329 + (1 << (d - 1))) >> d);
    endfunction

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Compare the results due now, then queue and drive the next input.
    task automatic step(input logic v, input logic op, input logic [1:0] ds,
                        input logic [47:0] c, input string tag);
        @(negedge clk);
        total++;
        if (out_valid !== p_v[1]) begin
            bad++;
            $display("FAIL R2 out_valid act=%0b exp=%0b", out_valid, p_v[1]);
        end
        if (p_v[1]) begin
            for (int i = 0; i < 4; i++) begin
                check(p_tag[1][i], out_coef[12*i +: 12], p_exp[1][i]);
                if (!p_op[1] && p_ds[1] != 2'd3)
                    check("R7", out_coef[12*i +: 12] >> dval(p_ds[1]), 12'd0);
            end
        end
        p_v[1]  = p_v[0];
        p_op[1] = p_op[0];
        p_ds[1] = p_ds[0];
        for (int i = 0; i < 4; i++) begin
            p_exp[1][i] = p_exp[0][i];
            p_tag[1][i] = p_tag[0][i];
            p_exp[0][i] = op ? ref_dec(int'(c[12*i +: 12]), dval(ds))
                             : ref_comp(int'(c[12*i +: 12]), dval(ds));
            p_tag[0][i] = (!op && ds == 2'd0 && c[12*i +: 12] >= 12'd2497) ? "R4" : tag;
        end
        p_v[0]   = v;
        p_op[0]  = op;
        p_ds[0]  = ds;
        in_valid = v;
        in_op    = op;
        in_dsel  = ds;
        in_coef  = c;
    endtask

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [47:0] c;
        for (int k = 0; k < 2; k++) begin
            p_v[k] = 1'b0; p_op[k] = 1'b0; p_ds[k] = 2'd0;
            for (int i = 0; i < 4; i++) begin p_exp[k][i] = '0; p_tag[k][i] = "R2"; end
        end
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_op    = 1'b1;
        in_dsel  = 2'd1;
        in_coef  = 48'hABC_DEF_123_456;
        repeat (3) @(negedge clk);
        total++;
        if (out_valid !== 1'b0) begin
            bad++; $display("FAIL R1 out_valid act=%0b exp=0", out_valid);
        end
        total++;
        if (out_coef !== 48'd0) begin
            bad++; $display("FAIL R1 out_coef act=%0h exp=0", out_coef);
        end
        rst_n    = 1'b1;
        in_valid = 1'b0;

        // R3 / R4: every residue compressed at each reduced width.
        for (int ds = 0; ds < 3; ds++) begin
            for (int cy = 0; cy < 833; cy++) begin
                for (int i = 0; i < 4; i++) c[12*i +: 12] = 12'((4*cy + i) % 3329);
                step(1'b1, 1'b0, 2'(ds), c, "R3");
            end
        end

        // R5: every code decompressed, with random bits above the code.
        for (int ds = 0; ds < 3; ds++) begin
            int d = dval(2'(ds));
            int n = 1 << d;
            for (int cy = 0; cy < (n + 3) / 4; cy++) begin
                for (int i = 0; i < 4; i++)
                    c[12*i +: 12] = 12'(((4*cy + i) % n) + (($urandom % 4096) << d));
                step(1'b1, 1'b1, 2'(ds), c, "R5");
            end
        end

        // R6: 12-bit width in both directions.
        for (int cy = 0; cy < 40; cy++) begin
            for (int i = 0; i < 4; i++) c[12*i +: 12] = 12'($urandom);
            step(1'b1, 1'(cy % 2), 2'd3, c, "R6");
        end

        // R2: bubbles between valid cycles.
        for (int cy = 0; cy < 40; cy++) begin
            for (int i = 0; i < 4; i++) c[12*i +: 12] = 12'($urandom % 3329);
            step(1'((cy / 3) % 2), 1'b0, 2'(cy % 3), c, "R2");
        end

        // R9: direction and width change on every cycle.
        for (int cy = 0; cy < 64; cy++) begin
            logic o;
            o = 1'($urandom);
            for (int i = 0; i < 4; i++)
                c[12*i +: 12] = o ? 12'($urandom) : 12'($urandom % 3329);
            step(1'b1, o, 2'($urandom), c, "R9");
        end

        // R8: lanes carry unrelated values side by side.
        step(1'b1, 1'b0, 2'd2, {12'd1665, 12'd0, 12'd3328, 12'd0}, "R8");
        step(1'b1, 1'b0, 2'd2, {12'd0, 12'd3328, 12'd0, 12'd1}, "R8");
        step(1'b1, 1'b1, 2'd1, {12'd31, 12'd0, 12'd17, 12'd4095}, "R8");

        // Drain the pipeline.
        repeat (3) step(1'b0, 1'b0, 2'd0, 48'd0, "R2");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule